// File: doc/BRIEF.md
# Scan Chain Flush Integrity Tester

This block proves that one or more scan chains shift correctly before any test vector is loaded through them. When started, it holds the test-control output in scan mode and drives a repeating two-zeros, two-ones stream into the scan input of every chain for exactly chain-length plus four shift clocks. Each chain's scan output is compared against the stream it was fed, delayed by the chain length. Over those clocks every flip-flop in a healthy chain holds a 0 then a 0, a 0 then a 1, a 1 then a 1, and a 1 then a 0.

Compares are made only once the stream has had time to traverse the chain. The first four bits expected at each scan output are therefore 0, 0, 1, 1. The block keeps a sticky failure flag, a per-chain failure mask and the cycle number of the first miscompare. The chains and the logic between them sit outside the block, and all chains share the one test-control line. A vector sequencer runs the tester as a preamble through a start/done handshake. When the test ends, the done level stays high until the next start.

Top module: `scan_flush_tester`

## Requirements
- R1: After reset, testCtrl is 1 (normal mode), busy, done and fail are 0, and failChains, firstFail and every scanIn bit are 0.
- R2: A start seen while idle or finished makes busy 1 and testCtrl 0 from the next cycle on. testCtrl then stays 0 for exactly CHAIN_LEN+4 consecutive cycles.
- R3: Run cycles are numbered t = 0, 1, 2, … from the first cycle after start. In run cycle t, every scanIn bit is 1 when t mod 4 is 2 or 3, and 0 when t mod 4 is 0 or 1. Outside a run, scanIn is 0.
- R4: A chain's scanOut is ignored in run cycles t < CHAIN_LEN, and fail stays 0 through them.
- R5: In run cycles t = CHAIN_LEN … CHAIN_LEN+3, scanOut of each chain must equal the scanIn value of cycle t−CHAIN_LEN, which is 0, 0, 1, 1 in that order. Any difference is a miscompare.
- R6: fail becomes 1 after any miscompare and stays 1 until the next accepted start. Bit i of failChains becomes 1 when chain i miscompares and stays 1 in the same way.
- R7: firstFail holds the run cycle number t of the earliest miscompare on any chain. It stays 0 when nothing miscompares.
- R8: busy falls and done rises together, CHAIN_LEN+4 cycles after busy rose. done, fail, failChains and firstFail then hold until the next start.
- R9: A start asserted while busy is 1 is ignored. The run length, the stimulus and the results are the same as with no such start.
- R10: An accepted start clears done, fail, failChains and firstFail in the first run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the scan chains |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a flush test |
| scanOut | input | NUM_CHAINS | Scan output of each chain |
| testCtrl | output | 1 | Chain mode: 0 shift, 1 normal |
| scanIn | output | NUM_CHAINS | Stimulus into each chain |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, results valid |
| fail | output | 1 | Sticky miscompare flag |
| failChains | output | NUM_CHAINS | Sticky per-chain miscompare mask |
| firstFail | output | CNT_W | Run cycle of the first miscompare |

## Verification
The bench models each chain with a selectable fault, so that faults at different points are caught in different cycles:
- A stuck-at-1 cell and an inverting chain must miscompare at cycle CHAIN_LEN.
- A chain one cell short must miscompare at CHAIN_LEN+1.
- A stuck-at-0 cell must miscompare at CHAIN_LEN+2.
- A chain one cell long with zeros preloaded must also miscompare at CHAIN_LEN+2.

A design whose compare window is off by one cycle, or whose expected stream has the wrong phase, reports the wrong firstFail or misses faults. Chains preloaded with ones catch a design that compares before the chain has filled: it raises fail on a healthy chain. A start pulsed in mid-run catches a design that restarts its count or clears its results while busy. Faults placed on two chains at once check that the per-chain mask and the earliest-cycle report are correct together.

// File: rtl/flush_pkg.sv
package flush_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } flushState_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clear;   // accepted start: zero counter and results
    logic run;     // shift cycle in progress
  } flushStrobe_t;

endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl
  import flush_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         lastCycle,
  output flushStrobe_t strobe,
  output logic         testCtrl,
  output logic         busy,
  output logic         done
);

  flushState_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_RUN;
        S_RUN:   if (lastCycle) state <= S_FIN;
        S_FIN:   if (start) state <= S_RUN;
        default: state <= S_IDLE;
      endcase
    end
  end

  // A start is accepted only outside a run; while running it is dropped.
  always_comb begin
    strobe.clear = start && (state != S_RUN);
    strobe.run   = (state == S_RUN);
  end

  assign testCtrl = (state != S_RUN);
  assign busy     = (state == S_RUN);
  assign done     = (state == S_FIN);

endmodule

// File: rtl/flush_dp.sv
module flush_dp
  import flush_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 16,
  parameter int CNT_W      = $clog2(CHAIN_LEN + 5)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  flushStrobe_t          strobe,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  lastCycle,
  output logic                  fail,
  output logic [NUM_CHAINS-1:0] failChains,
  output logic [CNT_W-1:0]      firstFail
);

  localparam logic [CNT_W-1:0] FILL_CNT = CNT_W'(CHAIN_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHAIN_LEN + 3);

  logic [CNT_W-1:0]      cycleCnt;
  logic [CNT_W-1:0]      lagCnt;
  logic                  stimBit;
  logic                  expBit;
  logic                  inWindow;
  logic [NUM_CHAINS-1:0] miss;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cycleCnt <= '0;
    else if (strobe.clear) cycleCnt <= '0;
    else if (strobe.run)   cycleCnt <= cycleCnt + 1'b1;
  end

  assign lastCycle = strobe.run && (cycleCnt == LAST_CNT);

  // Pattern 0,0,1,1 repeating is simply bit 1 of the cycle number.
  assign stimBit  = strobe.run && cycleCnt[1];
  assign inWindow = strobe.run && (cycleCnt >= FILL_CNT);
  assign lagCnt   = cycleCnt - FILL_CNT;
  assign expBit   = lagCnt[1];

  for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_chain
    assign scanIn[i] = stimBit;
    assign miss[i]   = inWindow && (scanOut[i] != expBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail       <= 1'b0;
      failChains <= '0;
      firstFail  <= '0;
    end else if (strobe.clear) begin
      fail       <= 1'b0;
      failChains <= '0;
      firstFail  <= '0;
    end else if (|miss) begin
      fail       <= 1'b1;
      failChains <= failChains | miss;
      if (!fail) firstFail <= cycleCnt;
    end
  end

endmodule

// File: rtl/scan_flush_tester.sv
module scan_flush_tester
  import flush_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 16,
  parameter int CNT_W      = $clog2(CHAIN_LEN + 5)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_CHAINS-1:0] scanOut,
  output logic                  testCtrl,
  output logic [NUM_CHAINS-1:0] scanIn,
  output logic                  busy,
  output logic                  done,
  output logic                  fail,
  output logic [NUM_CHAINS-1:0] failChains,
  output logic [CNT_W-1:0]      firstFail
);

  flushStrobe_t strobe;
  logic         lastCycle;

  flush_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .lastCycle (lastCycle),
    .strobe    (strobe),
    .testCtrl  (testCtrl),
    .busy      (busy),
    .done      (done)
  );

  flush_dp #(
    .NUM_CHAINS (NUM_CHAINS),
    .CHAIN_LEN  (CHAIN_LEN),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .scanOut    (scanOut),
    .scanIn     (scanIn),
    .lastCycle  (lastCycle),
    .fail       (fail),
    .failChains (failChains),
    .firstFail  (firstFail)
  );

endmodule

// File: rtl/scan_flush_checker.sv
module scan_flush_checker #(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 16,
  parameter int CNT_W      = $clog2(CHAIN_LEN + 5)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic                  testCtrl,
  input logic [NUM_CHAINS-1:0] scanIn,
  input logic                  busy,
  input logic                  done,
  input logic                  fail,
  input logic [NUM_CHAINS-1:0] failChains,
  input logic [CNT_W-1:0]      firstFail
);

  localparam int LW = $clog2(CHAIN_LEN + 6) + 1;

  // Cycles spent with testCtrl low; equals the run cycle number.
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lowCnt <= '0;
    else if (!testCtrl) lowCnt <= lowCnt + 1'b1;
    else               lowCnt <= '0;
  end

  p_tc_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (lowCnt == LW'(CHAIN_LEN + 4)));

  p_stim_r3: assert property (@(posedge clk) disable iff (!rstN)
    !testCtrl |-> (scanIn == {NUM_CHAINS{lowCnt[1]}}));

  p_idle_stim_r3: assert property (@(posedge clk) disable iff (!rstN)
    testCtrl |-> (scanIn == '0));

  p_no_early_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!testCtrl && lowCnt < LW'(CHAIN_LEN)) |=> !fail);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !(start && !busy)) |=> fail);

  p_done_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && lowCnt < LW'(CHAIN_LEN + 3)) |=> busy);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!fail && !done && failChains == '0 && firstFail == '0));

endmodule

bind scan_flush_tester scan_flush_checker #(
  .NUM_CHAINS (NUM_CHAINS),
  .CHAIN_LEN  (CHAIN_LEN),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .testCtrl   (testCtrl),
  .scanIn     (scanIn),
  .busy       (busy),
  .done       (done),
  .fail       (fail),
  .failChains (failChains),
  .firstFail  (firstFail)
);

// File: tb/scan_flush_tester_test.sv
module scan_flush_tester_test;

  localparam int N     = 3;
  localparam int L     = 5;
  localparam int CNT_W = $clog2(L + 5);

  // Fault kinds of the bench chain model
  localparam int K_GOOD  = 0;
  localparam int K_ST0   = 1;
  localparam int K_ST1   = 2;
  localparam int K_SHORT = 3;
  localparam int K_LONG  = 4;
  localparam int K_INV   = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [N-1:0]     scanOut;
  logic             testCtrl;
  logic [N-1:0]     scanIn;
  logic             busy, done, fail;
  logic [N-1:0]     failChains;
  logic [CNT_W-1:0] firstFail;

  int nChecks = 0;
  int nFails  = 0;

  int   kind [N];
  int   fpos [N];
  logic loadReq = 1'b0;
  logic loadBit = 1'b0;
  logic [L:0] chain [N];

  always #10 clk = ~clk;

  scan_flush_tester #(.NUM_CHAINS(N), .CHAIN_LEN(L), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .scanOut(scanOut),
    .testCtrl(testCtrl), .scanIn(scanIn), .busy(busy), .done(done),
    .fail(fail), .failChains(failChains), .firstFail(firstFail)
  );

  // External chain model with an injectable fault per chain.
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      logic [L:0] nxt;
      nxt = chain[i];
      if (loadReq) nxt = {(L+1){loadBit}};
      else if (!testCtrl) nxt = {chain[i][L-1:0], scanIn[i]};
      if (!loadReq && !testCtrl) begin
        if (kind[i] == K_ST0) nxt[fpos[i]] = 1'b0;
        if (kind[i] == K_ST1) nxt[fpos[i]] = 1'b1;
      end
      chain[i] <= nxt;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      case (kind[i])
        K_SHORT: scanOut[i] = chain[i][L-2];
        K_LONG:  scanOut[i] = chain[i][L];
        K_INV:   scanOut[i] = ~chain[i][L-1];
        default: scanOut[i] = chain[i][L-1];
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stim(input int k);
    return ((k % 4) >= 2) ? 1 : 0;
  endfunction

  // Scan output a chain of the given fault kind shows in run cycle t (t >= L)
  function automatic int modelOut(input int k, input int t, input int pre);
    case (k)
      K_ST0:   return 0;
      K_ST1:   return 1;
      K_SHORT: return stim(t - L + 1);
      K_LONG:  return (t - L - 1 < 0) ? pre : stim(t - L - 1);
      K_INV:   return 1 - stim(t - L);
      default: return stim(t - L);
    endcase
  endfunction

  task automatic runTest(input int pre, input bit midStart);
    int expFirst = -1;
    int expMask  = 0;
    int seen;
    // R5 / R7: expected results computed from the fault models
    for (int t = L; t < L + 4; t++)
      for (int i = 0; i < N; i++)
        if (modelOut(kind[i], t, pre) != stim(t - L)) begin
          expMask |= (1 << i);
          if (expFirst < 0) expFirst = t;
        end
    @(negedge clk);
    loadBit = pre[0];
    loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = -1;
    for (int t = 0; t < L + 8; t++) begin
      if (done) begin seen = t; break; end
      check(testCtrl == 1'b0 && busy, "R2 testCtrl low while running", int'(testCtrl), 0);
      check(scanIn == {N{stim(t) == 1}}, "R3 stimulus bit", int'(scanIn), stim(t) * ((1 << N) - 1));
      if (t == 0) check(!fail && failChains == 0 && firstFail == 0, "R10 results cleared",
                        int'(fail), 0);
      if (t <= L) check(!fail, "R4 no compare before fill", int'(fail), 0);
      if (midStart && t == 2) start = 1'b1;
      if (midStart && t == 3) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(seen == L + 4, "R2 R8 R9 run length", seen, L + 4);
    check(testCtrl && !busy && scanIn == 0, "R3 R8 idle after run", int'(testCtrl), 1);
    check(fail == (expFirst >= 0), "R5 R6 fail flag", int'(fail), int'(expFirst >= 0));
    check(int'(failChains) == expMask, "R6 failChains", int'(failChains), expMask);
    check(int'(firstFail) == ((expFirst < 0) ? 0 : expFirst), "R7 firstFail",
          int'(firstFail), (expFirst < 0) ? 0 : expFirst);
    repeat (3) @(negedge clk);
    check(done && int'(failChains) == expMask, "R8 done holds", int'(done), 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      kind[i]  = K_GOOD;
      fpos[i]  = 0;
      chain[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(testCtrl && !busy && !done && !fail, "R1 reset controls", int'(testCtrl), 1);
    check(failChains == 0 && firstFail == 0 && scanIn == 0, "R1 reset results",
          int'(firstFail), 0);
    rstN = 1'b1;
    @(negedge clk);
    // Sweep every fault kind on every chain, every stuck position, both preloads
    for (int c = 0; c < N; c++)
      for (int k = K_GOOD; k <= K_INV; k++)
        for (int p = 0; p < L; p++) begin
          if (p > 0 && k != K_ST0 && k != K_ST1) continue;
          for (int pre = 0; pre < 2; pre++) begin
            for (int i = 0; i < N; i++) kind[i] = K_GOOD;
            kind[c] = k;
            fpos[c] = p;
            runTest(pre, (pre == 1));
          end
        end
    // Two faulty chains at once: earliest cycle and combined mask
    for (int i = 0; i < N; i++) kind[i] = K_GOOD;
    kind[0] = K_ST0; fpos[0] = 1;
    kind[N-1] = K_SHORT;
    runTest(0, 1'b0);
    kind[0] = K_INV;
    runTest(1, 1'b1);
    // Back to a healthy set: everything clears (R10)
    for (int i = 0; i < N; i++) kind[i] = K_GOOD;
    runTest(0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule